// File: doc/BRIEF.md
# Modulo Circular Address Generator

This block forms effective addresses for circular data buffers held in byte-addressed memory. Each request carries a pointer value read from a register-file entry, the index of that entry, an addressing mode and a signed step. The block adds the step to the pointer. If circular operation applies to the request, it folds the sum back into the configured window: a forward step is compared against the window's last element and a backward step against its first.

The block returns two results, one clock after the request. The first is the address to use for the access. The second is, when the mode calls for it, the value to store back into the pointer register. Circular operation is configured by an enable bit, the index of the one pointer it governs, and the first and last element addresses of the window. Elements are 16-bit words, so the window length in bytes is last minus first plus two.

On the write path, circular correction gives way when bit-reversed addressing is active. The read path always keeps it.

Top module: `modaddr_gen`

## Requirements
- R1: The outputs are registered. `o_valid` equals `i_valid` of the previous clock. While `rst_n` is low, all outputs read zero.
- R2: Circular correction applies to a request only when all three of these hold: `i_mod_en` is 1, `i_ptr_sel` equals `i_mod_ptr`, and the request is not a write (`i_is_write`=1) with bit-reversed addressing active (`i_brev_on`=1).
- R3: For a non-negative step (bit 15 of `i_modifier` clear), if correction applies and pointer plus step is strictly greater than `i_buf_end`, the corrected address is the sum minus (`i_buf_end` - `i_buf_start` + 2).
- R4: For a negative step, if correction applies and pointer plus step is strictly less than `i_buf_start`, the corrected address is the sum plus (`i_buf_end` - `i_buf_start` + 2).
- R5: A sum landing exactly on `i_buf_end` or `i_buf_start` is left unchanged. A sum that overshoots a boundary by several elements is still folded by exactly one window length.
- R6: The mode encodings are 0 = plain indirect, 1 = post-modify, 2 = pre-modify, 3 = register plus offset. `o_wb_en` is 1 only for modes 1 and 2. In mode 0, `o_ea` is the unmodified pointer.
- R7: In post-modify mode, `o_ea` is the unmodified pointer and `o_wb_data` is the corrected address. In pre-modify mode, both `o_ea` and `o_wb_data` are the corrected address.
- R8: In register-plus-offset mode, `o_ea` is the corrected address and no write-back is requested, so the pointer register keeps its value.
- R9: A read with bit-reversed addressing active is still corrected. A write with it active gets the uncorrected sum.
- R10: When correction does not apply, the result is the plain 16-bit sum, which wraps modulo 2^16.
- R11: `o_wb_sel` repeats the `i_ptr_sel` of the request it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Request strobe |
| i_ptr_sel | input | 4 | Index of the pointer register |
| i_ptr | input | 16 | Current pointer value |
| i_mode | input | 2 | Addressing mode (0 plain, 1 post, 2 pre, 3 offset) |
| i_modifier | input | 16 | Signed step or offset in bytes |
| i_is_write | input | 1 | Request is a data write |
| i_brev_on | input | 1 | Bit-reversed addressing active on this pointer |
| i_mod_en | input | 1 | Circular operation enable |
| i_mod_ptr | input | 4 | Pointer index that circular operation governs |
| i_buf_start | input | 16 | First element address of the window |
| i_buf_end | input | 16 | Last element address of the window |
| o_valid | output | 1 | Result strobe |
| o_ea | output | 16 | Effective address for the access |
| o_wb_en | output | 1 | Pointer write-back request |
| o_wb_sel | output | 4 | Pointer index to write back |
| o_wb_data | output | 16 | Value to write back |

## Verification
Directed steps place the sum one element short of each boundary, exactly on it, and several elements past it. These cases separate a strict comparison from an equality test or an inclusive one, and show whether an overshoot is folded by a full window length.

The same wrapping step is then sent in each of the four modes. This shows which mode addresses with the old pointer, which with the corrected one, and which requests write-back.

The gating cases change one condition at a time: a read versus a write under bit-reversed addressing, another pointer index, and the enable bit cleared. A randomized sweep across window placements, step signs and magnitudes follows, checked against a behavioural model on every clock.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;

  typedef enum logic [1:0] {
    AM_PLAIN  = 2'd0,
    AM_POST   = 2'd1,
    AM_PRE    = 2'd2,
    AM_OFFSET = 2'd3
  } am_mode_e;

endpackage

// File: rtl/modaddr_gate.sv
module modaddr_gate #(
  parameter int PSW = 4
) (
  input  logic           mod_en,
  input  logic [PSW-1:0] ptr_sel,
  input  logic [PSW-1:0] mod_ptr,
  input  logic           is_write,
  input  logic           brev_on,
  output logic           apply
);
  logic sel_hit;
  logic wr_brev_block;

  always_comb begin
    sel_hit       = (ptr_sel == mod_ptr);
    // bit-reversal takes the write path; reads keep circular correction
    wr_brev_block = is_write & brev_on;
    apply         = mod_en & sel_hit & ~wr_brev_block;
  end
endmodule

// File: rtl/modaddr_wrap.sv
module modaddr_wrap #(
  parameter int AW         = 16,
  parameter int ELEM_BYTES = 2
) (
  input  logic          apply,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] fixed
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum_s;
  logic signed [EW-1:0] lo_s;
  logic signed [EW-1:0] hi_s;
  logic signed [EW-1:0] len_s;
  logic                 going_up;
  logic                 over_hi;
  logic                 under_lo;

  always_comb begin
    sum_s    = $signed({2'b00, base}) + $signed({{2{step[AW-1]}}, step});
    lo_s     = $signed({2'b00, lo});
    hi_s     = $signed({2'b00, hi});
    len_s    = hi_s - lo_s + EW'(ELEM_BYTES);
    going_up = ~step[AW-1];
    // strict comparisons: an overshoot of any size is still caught
    over_hi  = apply &  going_up & (sum_s > hi_s);
    under_lo = apply & ~going_up & (sum_s < lo_s);
    if (over_hi) begin
      fixed = AW'(sum_s - len_s);
    end else if (under_lo) begin
      fixed = AW'(sum_s + len_s);
    end else begin
      fixed = AW'(sum_s);
    end
  end
endmodule

// File: rtl/modaddr_route.sv
module modaddr_route
  import modaddr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] fixed,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  am_mode_e m;

  always_comb begin
    m       = am_mode_e'(mode);
    ea      = ptr;
    wb_en   = 1'b0;
    wb_data = fixed;
    unique case (m)
      AM_PLAIN:  begin ea = ptr;   wb_en = 1'b0; end
      AM_POST:   begin ea = ptr;   wb_en = 1'b1; end
      AM_PRE:    begin ea = fixed; wb_en = 1'b1; end
      AM_OFFSET: begin ea = fixed; wb_en = 1'b0; end
      default:   begin ea = ptr;   wb_en = 1'b0; end
    endcase
  end
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
  import modaddr_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NUM_PTR    = 16,
  parameter int ELEM_BYTES = 2,
  parameter int OUT_STAGE  = 1,
  localparam int PSW       = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           i_valid,
  input  logic [PSW-1:0] i_ptr_sel,
  input  logic [AW-1:0]  i_ptr,
  input  logic [1:0]     i_mode,
  input  logic [AW-1:0]  i_modifier,
  input  logic           i_is_write,
  input  logic           i_brev_on,
  input  logic           i_mod_en,
  input  logic [PSW-1:0] i_mod_ptr,
  input  logic [AW-1:0]  i_buf_start,
  input  logic [AW-1:0]  i_buf_end,
  output logic           o_valid,
  output logic [AW-1:0]  o_ea,
  output logic           o_wb_en,
  output logic [PSW-1:0] o_wb_sel,
  output logic [AW-1:0]  o_wb_data
);
  logic          apply;
  logic [AW-1:0] fixed;
  logic [AW-1:0] ea_n;
  logic          wb_en_n;
  logic [AW-1:0] wb_data_n;

  modaddr_gate #(.PSW(PSW)) u_gate (
    .mod_en   (i_mod_en),
    .ptr_sel  (i_ptr_sel),
    .mod_ptr  (i_mod_ptr),
    .is_write (i_is_write),
    .brev_on  (i_brev_on),
    .apply    (apply)
  );

  modaddr_wrap #(.AW(AW), .ELEM_BYTES(ELEM_BYTES)) u_wrap (
    .apply (apply),
    .base  (i_ptr),
    .step  (i_modifier),
    .lo    (i_buf_start),
    .hi    (i_buf_end),
    .fixed (fixed)
  );

  modaddr_route #(.AW(AW)) u_route (
    .mode    (i_mode),
    .ptr     (i_ptr),
    .fixed   (fixed),
    .ea      (ea_n),
    .wb_en   (wb_en_n),
    .wb_data (wb_data_n)
  );

  generate
    if (OUT_STAGE != 0) begin : g_reg
      logic           valid_q;
      logic [AW-1:0]  ea_q;
      logic           wb_en_q;
      logic [PSW-1:0] wb_sel_q;
      logic [AW-1:0]  wb_data_q;
      logic           valid_d;
      logic [AW-1:0]  ea_d;
      logic           wb_en_d;
      logic [PSW-1:0] wb_sel_d;
      logic [AW-1:0]  wb_data_d;

      always_comb begin
        valid_d   = i_valid;
        ea_d      = ea_q;
        wb_en_d   = wb_en_q;
        wb_sel_d  = wb_sel_q;
        wb_data_d = wb_data_q;
        if (i_valid) begin
          ea_d      = ea_n;
          wb_en_d   = wb_en_n;
          wb_sel_d  = i_ptr_sel;
          wb_data_d = wb_data_n;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q   <= 1'b0;
          ea_q      <= '0;
          wb_en_q   <= 1'b0;
          wb_sel_q  <= '0;
          wb_data_q <= '0;
        end else begin
          valid_q   <= valid_d;
          ea_q      <= ea_d;
          wb_en_q   <= wb_en_d;
          wb_sel_q  <= wb_sel_d;
          wb_data_q <= wb_data_d;
        end
      end

      assign o_valid   = valid_q;
      assign o_ea      = ea_q;
      assign o_wb_en   = wb_en_q;
      assign o_wb_sel  = wb_sel_q;
      assign o_wb_data = wb_data_q;

      p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == $past(i_valid));

      p_wb_only_modify_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_wb_en) |-> ($past(i_mode) == 2'd1 || $past(i_mode) == 2'd2));

      p_offset_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && i_mode == 2'd3) |-> !o_wb_en);

      p_post_uses_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && i_mode == 2'd1) |-> (o_ea == $past(i_ptr)));

      p_pre_ea_matches_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && i_mode == 2'd2) |-> (o_ea == o_wb_data));

      p_bypass_plain_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid && !i_mod_en && i_mode == 2'd2)
          |-> (o_ea == AW'($past(i_ptr) + $past(i_modifier))));

      p_sel_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i_valid) |-> (o_wb_sel == $past(i_ptr_sel)));
    end else begin : g_comb
      assign o_valid   = i_valid;
      assign o_ea      = ea_n;
      assign o_wb_en   = wb_en_n;
      assign o_wb_sel  = i_ptr_sel;
      assign o_wb_data = wb_data_n;
    end
  endgenerate
endmodule

// File: tb/sim_modaddr_gen.sv
`timescale 1ns/1ps
module sim_modaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_valid;
  logic [3:0]  i_ptr_sel;
  logic [15:0] i_ptr;
  logic [1:0]  i_mode;
  logic [15:0] i_modifier;
  logic        i_is_write;
  logic        i_brev_on;
  logic        i_mod_en;
  logic [3:0]  i_mod_ptr;
  logic [15:0] i_buf_start;
  logic [15:0] i_buf_end;
  logic        o_valid;
  logic [15:0] o_ea;
  logic        o_wb_en;
  logic [3:0]  o_wb_sel;
  logic [15:0] o_wb_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic        e_valid;
  logic [15:0] e_ea;
  logic        e_wb_en;
  logic [3:0]  e_wb_sel;
  logic [15:0] e_wb_data;
  string       e_tag;

  always #2.5 clk = ~clk;

  modaddr_gen u0 (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ptr_sel(i_ptr_sel),
    .i_ptr(i_ptr), .i_mode(i_mode), .i_modifier(i_modifier),
    .i_is_write(i_is_write), .i_brev_on(i_brev_on), .i_mod_en(i_mod_en),
    .i_mod_ptr(i_mod_ptr), .i_buf_start(i_buf_start), .i_buf_end(i_buf_end),
    .o_valid(o_valid), .o_ea(o_ea), .o_wb_en(o_wb_en), .o_wb_sel(o_wb_sel),
    .o_wb_data(o_wb_data)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "valid", int'(o_valid), int'(e_valid));
    if (e_valid) begin
      chk(e_tag, "ea", int'(o_ea), int'(e_ea));
      chk(e_tag, "wb_en", int'(o_wb_en), int'(e_wb_en));
      chk(e_tag, "wb_sel", int'(o_wb_sel), int'(e_wb_sel));
      if (e_wb_en) chk(e_tag, "wb_data", int'(o_wb_data), int'(e_wb_data));
    end
  endtask

  // behavioural reference: integer arithmetic from the requirements
  task automatic send(string tag, bit v, int sel, int ptr, int mode, int step,
                      bit wr, bit brev, bit en, int mptr);
    int s, len, corr;
    bit use_mod;
    @(negedge clk);
    compare();
    i_valid = v; i_ptr_sel = 4'(sel); i_ptr = 16'(ptr); i_mode = 2'(mode);
    i_modifier = 16'(step); i_is_write = wr; i_brev_on = brev;
    i_mod_en = en; i_mod_ptr = 4'(mptr);
    s       = ptr + int'($signed(16'(step)));
    len     = int'(i_buf_end) - int'(i_buf_start) + 2;
    use_mod = en && (sel == mptr) && !(wr && brev);
    corr    = s;
    if (use_mod && ($signed(16'(step)) >= 0) && s > int'(i_buf_end)) corr = s - len;
    else if (use_mod && ($signed(16'(step)) < 0) && s < int'(i_buf_start)) corr = s + len;
    corr = corr & 16'hFFFF;
    e_tag     = tag;
    e_valid   = v;
    e_wb_sel  = 4'(sel);
    e_wb_data = 16'(corr);
    e_wb_en   = (mode == 1) || (mode == 2);
    e_ea      = (mode == 0 || mode == 1) ? 16'(ptr) : 16'(corr);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; i_valid = 0; i_ptr_sel = 0; i_ptr = 0; i_mode = 0;
    i_modifier = 0; i_is_write = 0; i_brev_on = 0; i_mod_en = 0; i_mod_ptr = 0;
    i_buf_start = 16'h1000; i_buf_end = 16'h101E;
    e_valid = 0; e_ea = 0; e_wb_en = 0; e_wb_sel = 0; e_wb_data = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset valid", int'(o_valid), 0);
    chk("R1", "reset ea", int'(o_ea), 0);
    chk("R1", "reset wb_en", int'(o_wb_en), 0);
    chk("R1", "reset wb_data", int'(o_wb_data), 0);
    rst_n = 1'b1;
    // window 0x1000..0x101E, len 0x20
    send("R3", 1, 5, 'h101E, 2,   2, 0, 0, 1, 5);
    send("R5", 1, 5, 'h101C, 2,   2, 0, 0, 1, 5);
    send("R5", 1, 5, 'h101A, 2,   8, 0, 0, 1, 5);
    send("R4", 1, 5, 'h1000, 2,  -2, 0, 0, 1, 5);
    send("R5", 1, 5, 'h1002, 2,  -2, 0, 0, 1, 5);
    send("R4", 1, 5, 'h1004, 2, -10, 0, 0, 1, 5);
    send("R1", 0, 5, 'h1004, 2, -10, 0, 0, 1, 5);
    send("R6", 1, 5, 'h101E, 0,   2, 0, 0, 1, 5);
    send("R7", 1, 5, 'h101E, 1,   2, 0, 0, 1, 5);
    send("R7", 1, 5, 'h101E, 2,   4, 0, 0, 1, 5);
    send("R8", 1, 5, 'h101E, 3,   6, 0, 0, 1, 5);
    send("R9", 1, 5, 'h101E, 2,   2, 1, 1, 1, 5);
    send("R9", 1, 5, 'h101E, 2,   2, 0, 1, 1, 5);
    send("R2", 1, 6, 'h101E, 2,   2, 0, 0, 1, 5);
    send("R2", 1, 5, 'h101E, 2,   2, 0, 0, 0, 5);
    send("R10", 1, 3, 'hFFFE, 2,  4, 0, 0, 0, 5);
    send("R11", 1, 15, 'h1010, 1, 2, 0, 0, 1, 15);
    for (int k = 0; k < 3000; k++) begin
      int st, ln, pt, sp, sel;
      if (k % 64 == 0) begin
        @(negedge clk);
        compare();
        e_valid = 0; i_valid = 0;
        st = int'($urandom_range(0, 16'h7F00)) & 'hFFFE;
        ln = (int'($urandom_range(1, 64))) * 2;
        i_buf_start = 16'(st);
        i_buf_end   = 16'(st + ln - 2);
        e_tag = "R1";
      end
      pt  = int'(i_buf_start) + (int'($urandom_range(0, 80)) * 2) - 16;
      sp  = (int'($urandom_range(0, 40)) - 20) * 2;
      sel = int'($urandom_range(0, 3));
      send(sp >= 0 ? "R3" : "R4", 1, sel, pt, int'($urandom_range(0, 3)), sp,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) != 0), 1);
    end
    send("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule